// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel byte into one asynchronous serial frame on a single output line. A write strobe, given together with the byte, starts a frame. A busy flag then stays high until the last stop bit has been sent. The line rests high between frames. Each frame holds, in order on the wire:

- a low start bit,
- the data bits, least significant first,
- an optional parity bit,
- one or two high stop bits.

Four runtime settings shape the frame: the data width (7 or 8 bits), the parity (off, odd or even), the stop length (one or two bit times) and one of four standard bit rates. The block takes a snapshot of all settings and the byte at the accepted write. It ignores them after that until the frame ends. An internal divider produces the bit timing from the system clock. Its divide value is the clock frequency divided by the chosen rate, rounded to the nearest integer. The clock frequency is the parameter `CLK_HZ`.

Top module: `uart_tx_top`

## Requirements
- R1: After reset, and whenever `busy` is low, `tx_line` is high and `busy` is low until a write is accepted.
- R2: A write (`wr_en` high while `busy` is low) at a rising edge sets `busy` high and drives the start bit (low) on `tx_line` from that edge on, for exactly one bit time.
- R3: The data bits follow the start bit, least significant bit first. There are 8 when `cfg_eight_bits` is 1 and 7 when it is 0. In 7-bit mode `wr_data[7]` is not sent.
- R4: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd` = 1 the total count of ones over the data and parity is odd, and with 0 it is even. When `cfg_par_en` is 0, no parity bit is sent.
- R5: One high stop bit ends the frame when `cfg_two_stop` is 0, and two when it is 1.
- R6: Every bit lasts DIV cycles, where DIV = round(CLK_HZ / rate). The rate is set by `cfg_baud_sel`: 0 = 1200, 1 = 2400, 2 = 4800, 3 = 9600 bit/s.
- R7: A write strobe that arrives while `busy` is high is ignored. The frame in progress continues unchanged.
- R8: Changes to `wr_data` or any `cfg_*` input during a frame have no effect on that frame.
- R9: `busy` falls exactly N*DIV cycles after the accepting edge, where N = 1 + data bits + parity bits + stop bits. At that point `tx_line` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe; starts a frame when idle |
| wr_data | input | 8 | Byte to send |
| cfg_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: send a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_baud_sel | input | 2 | Rate select: 0=1200, 1=2400, 2=4800, 3=9600 |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | High from accepted write until end of last stop bit |

## Verification
Take the rising edge that accepts a write as cycle 0. Bit k of the frame holds on `tx_line` from cycle k*DIV to cycle (k+1)*DIV-1. `busy` stays high through cycle N*DIV-1 and is low, with the line high, from cycle N*DIV. The bench counts falling edges after the accepting edge. It samples each bit in the middle of its window, and it samples `busy` exactly one cycle before and at the cycle where it must fall. Between those samples it scrambles the data and settings and pulses the write strobe on every falling edge, so the expected frame, computed from the values given at the write, also shows that the block ignores them.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_MAX  = 8;
    localparam int FRAME_MAX = 12;
    localparam int LEN_W     = 4;

    typedef enum logic [1:0] {
        RATE_1200 = 2'd0,
        RATE_2400 = 2'd1,
        RATE_4800 = 2'd2,
        RATE_9600 = 2'd3
    } rate_sel_e;

    typedef struct packed {
        logic       eight;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
        logic [1:0] rate;
    } tx_cfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    function automatic int unsigned rate_bps(logic [1:0] sel);
        return 32'd1200 << sel;
    endfunction

    function automatic int unsigned rate_div(int unsigned clk_hz, logic [1:0] sel);
        int unsigned r;
        r = rate_bps(sel);
        return (clk_hz + r / 2) / r;
    endfunction

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  logic [DATA_MAX-1:0] data,
    input  tx_cfg_t             cfg,
    output frame_t              frame
);

    logic [LEN_W-1:0]     n_data;
    logic [LEN_W-1:0]     pos;
    logic [DATA_MAX-1:0]  masked;
    logic                 par_bit;
    logic [FRAME_MAX-1:0] f;

    always_comb begin
        n_data  = cfg.eight ? LEN_W'(8) : LEN_W'(7);
        masked  = cfg.eight ? data : {1'b0, data[DATA_MAX-2:0]};
        par_bit = (^masked) ^ cfg.par_odd;
        f       = '1;
        f[0]    = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < int'(n_data)) begin
                f[1 + i] = data[i];
            end
        end
        pos = LEN_W'(1) + n_data;
        if (cfg.par_en) begin
            f[pos] = par_bit;
            pos    = pos + LEN_W'(1);
        end
        frame.bits = f;
        frame.len  = pos + (cfg.two_stop ? LEN_W'(2) : LEN_W'(1));
    end

endmodule

// File: rtl/uart_tx_rate_gen.sv
module uart_tx_rate_gen
    import uart_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int          CNT_W  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] sel,
    input  logic       run,
    output logic       tick
);

    logic [CNT_W-1:0] div_tab [4];
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;

    for (genvar g = 0; g < 4; g++) begin : g_div
        assign div_tab[g] = CNT_W'(rate_div(CLK_HZ, 2'(g)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            div_q <= div_tab[sel];
            cnt_q <= div_tab[sel] - CNT_W'(1);
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_q <= div_q - CNT_W'(1);
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign tick = run && (cnt_q == '0);

    // R6: the down-counter stays inside the latched bit period while a frame runs
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run && !start |-> cnt_q < div_q);

    // R6: a tick reloads the period counter for the next bit
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        tick && !start |=> cnt_q == div_q - CNT_W'(1));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame,
    input  logic   tick,
    output logic   tx,
    output logic   busy
);

    logic [FRAME_MAX-1:0] sh_q;
    logic [LEN_W-1:0]     left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            left_q <= '0;
            tx     <= 1'b1;
            busy   <= 1'b0;
        end else if (load) begin
            sh_q   <= {1'b1, frame.bits[FRAME_MAX-1:1]};
            tx     <= frame.bits[0];
            left_q <= frame.len;
            busy   <= 1'b1;
        end else if (busy && tick) begin
            if (left_q == LEN_W'(1)) begin
                busy   <= 1'b0;
                tx     <= 1'b1;
                left_q <= '0;
            end else begin
                tx     <= sh_q[0];
                sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
                left_q <= left_q - LEN_W'(1);
            end
        end
    end

    // R1: idle line is high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    // R9: the frame ends only on a bit boundary
    a_r9_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick));

    // R7/R8: between bit boundaries the line and the pending bits hold
    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        busy && !tick |=> $stable(tx) && $stable(sh_q) && busy);

    // R9: remaining bit count never exceeds the largest frame
    a_r9_len_bound: assert property (@(posedge clk) disable iff (rst)
        left_q <= LEN_W'(FRAME_MAX));

endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
    import uart_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cfg_eight_bits,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic [1:0] cfg_baud_sel,
    output logic       tx_line,
    output logic       busy
);

    localparam int CNT_W = $clog2(rate_div(CLK_HZ, 2'd0) + 1);

    tx_cfg_t cfg_in;
    frame_t  frame;
    logic    accept;
    logic    tick;

    assign cfg_in = '{eight:    cfg_eight_bits,
                      par_en:   cfg_par_en,
                      par_odd:  cfg_par_odd,
                      two_stop: cfg_two_stop,
                      rate:     cfg_baud_sel};

    assign accept = wr_en && !busy;

    uart_tx_framer u_framer (
        .data  (wr_data),
        .cfg   (cfg_in),
        .frame (frame)
    );

    uart_tx_rate_gen #(
        .CLK_HZ (CLK_HZ),
        .CNT_W  (CNT_W)
    ) u_rate (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .sel   (cfg_baud_sel),
        .run   (busy),
        .tick  (tick)
    );

    uart_tx_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .frame (frame),
        .tick  (tick),
        .tx    (tx_line),
        .busy  (busy)
    );

    // R2: an accepted write starts with a low start bit and raises busy
    a_r2_start_bit: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy && !tx_line);

    // R7: a strobe during a frame never restarts it
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy && wr_en && !tick |=> busy && $stable(tx_line));

endmodule

// File: tb/uart_tx_top_tb_top.sv
module uart_tx_top_tb_top;

    localparam int unsigned CLK_HZ = 192_000;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       cfg_eight_bits, cfg_par_en, cfg_par_odd, cfg_two_stop;
    logic [1:0] cfg_baud_sel;
    logic       tx_line, busy;

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    bit  done   = 0;

    always #2.5 clk = ~clk;

    uart_tx_top #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .cfg_eight_bits (cfg_eight_bits),
        .cfg_par_en     (cfg_par_en),
        .cfg_par_odd    (cfg_par_odd),
        .cfg_two_stop   (cfg_two_stop),
        .cfg_baud_sel   (cfg_baud_sel),
        .tx_line        (tx_line),
        .busy           (busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_div(input int sel);
        int r;
        r = 1200 << sel;
        return (int'(CLK_HZ) + r / 2) / r;
    endfunction

    function automatic void ref_frame(input logic [7:0] d, input bit eight, input bit pen,
                                      input bit podd, input bit two,
                                      output bit f[12], output int n, output int pidx);
        int nd;
        int ones;
        nd = eight ? 8 : 7;
        ones = 0;
        for (int i = 0; i < 12; i++) f[i] = 1'b1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f[1 + i] = d[i];
            if (d[i]) ones++;
        end
        n = 1 + nd;
        pidx = -1;
        if (pen) begin
            f[n] = podd ? ((ones % 2) == 0) : ((ones % 2) == 1);
            pidx = n;
            n++;
        end
        n = n + (two ? 2 : 1);
    endfunction

    task automatic send(input logic [7:0] d, input bit eight, input bit pen, input bit podd,
                        input bit two, input int sel, input bit scramble);
        bit f[12];
        int n, pidx, dv, nd;
        string tag;
        ref_frame(d, eight, pen, podd, two, f, n, pidx);
        dv = exp_div(sel);
        nd = eight ? 8 : 7;
        @(negedge clk);
        check(busy == 1'b0 && tx_line == 1'b1, "R1 idle before write", int'(busy), 0);
        wr_data = d; cfg_eight_bits = eight; cfg_par_en = pen; cfg_par_odd = podd;
        cfg_two_stop = two; cfg_baud_sel = 2'(sel); wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        for (int j = 0; j <= n * dv; j++) begin
            if ((j % dv) == dv / 2) begin
                int k;
                k = j / dv;
                if (k == 0) tag = "R2 start bit";
                else if (k <= nd) tag = "R3 data bit";
                else if (k == pidx) tag = "R4 parity bit";
                else tag = "R5 stop bit";
                check(tx_line == f[k], tag, int'(tx_line), int'(f[k]));
            end
            if (j == n * dv - 1)
                check(busy == 1'b1, "R6 R9 busy before end", int'(busy), 1);
            if (j == n * dv) begin
                check(busy == 1'b0, "R6 R9 busy falls", int'(busy), 0);
                check(tx_line == 1'b1, "R9 line high at end", int'(tx_line), 1);
            end
            if (scramble && j < n * dv - 1) begin
                // R7 R8: strobes and setting changes mid-frame must be ignored
                wr_en = 1'($urandom);
                wr_data = 8'($urandom);
                {cfg_eight_bits, cfg_par_en, cfg_par_odd, cfg_two_stop} = 4'($urandom);
                cfg_baud_sel = 2'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190_000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190_000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        cfg_eight_bits = 1'b1; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        cfg_two_stop = 1'b0; cfg_baud_sel = 2'd3;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tx_line == 1'b1, "R1 reset line", int'(tx_line), 1);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        repeat (5) @(negedge clk);
        check(tx_line == 1'b1 && busy == 1'b0, "R1 stays idle", int'(tx_line), 1);

        // directed corners
        send(8'hA5, 1, 0, 0, 0, 3, 0);       // R3 plain 8N1
        send(8'h80, 0, 0, 0, 0, 3, 0);       // R3 7-bit drops bit 7
        send(8'h07, 1, 1, 1, 0, 2, 0);       // R4 odd parity
        send(8'h07, 1, 1, 0, 0, 2, 0);       // R4 even parity
        send(8'h00, 0, 1, 1, 1, 1, 0);       // R4 R5 zero data odd, two stop
        send(8'hFF, 1, 1, 0, 1, 0, 0);       // R5 R6 longest frame, slowest rate
        send(8'h3C, 1, 1, 1, 1, 3, 1);       // R7 R8 scrambled mid-frame

        // random frames, many scrambled
        for (int t = 0; t < 24; t++) begin
            send(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), int'($urandom % 4), 1'($urandom));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule